// File: doc/BRIEF.md
# Split-Transaction Card Bus Master

This block sequences CPU accesses to an external card-interface companion over a synchronous expansion bus that it shares with a display DMA requester. The CPU presents an address, a write flag, a size (one-beat or two-beat) and, for writes, data. The block then wins the shared bus through a request/grant pair, asserts the chip select of one of two companion devices, and runs a two-clock request phase. At the end of that phase it samples the companion's ready line.

If ready is high, the access flows straight into its data beats as one combined cycle. If ready is low, the companion does not yet hold the data, so the access is split. The block parks the access, drops the chip select and its bus request so that DMA can use the bus, and waits for ready. When ready returns it requests the bus again. Once granted, it spends one resume clock with the same chip select and address, then moves the data.

The CPU side sees a single done pulse only after the whole access has ended. There is no time-out. The block waits on ready for as long as it takes, because the companion is responsible for closing a failed access.

Top module: `cardBusMaster`

## Requirements
- R1: After reset, or when reset is applied in the middle of an access, `busReq`, `cardCs` and `cpuDone` are low and the block is idle. A later rise of `cardReady` with no CPU request does not restart the abandoned access.
- R2: `busReq` rises in the clock after a CPU request is taken. `cardCs` is high only while `busGnt` is high. No chip select is driven before the grant arrives.
- R3: With an immediate grant, a request phase asserts the chip select for two clocks. If `cardReady` is high when the second clock ends, the data beats follow with no break. The CPU request to `cpuDone` latency is then 6 clocks for a word and 5 for a byte, plus one clock for every clock the grant is delayed.
- R4: If `cardReady` is low when the second request clock ends, then in the next clock and for as long as the access stays parked, `busReq` and `cardCs` are low.
- R5: Once parked, a high `cardReady` makes the block raise `busReq` again. After the grant comes, one resume clock with the same chip select and address precedes the data beats. A split word access therefore holds the chip select for 5 clocks, and a split byte access for 4.
- R6: A word (`cpuWord`=1) moves in two beats and a byte in one. On a read, `cpuRdata` holds the first beat in bits [7:0] and the second in bits [15:8]. A byte read has bits [15:8] set to zero.
- R7: On a write, `busWe` is high while the chip select is driven. `busWdata` carries `cpuWdata[7:0]` in the first data beat and `cpuWdata[15:8]` in the second.
- R8: `cpuDone` is a one-clock pulse, given exactly once per access, in the clock after the last data beat. In that clock `busReq` and `cardCs` are low.
- R9: There is no time-out. An access stays parked for any number of clocks (300 in the test) and still completes normally when ready returns.
- R10: The select index and the address are taken when the request is accepted. Changes on `cpuSel` and `cpuAddr` during the access have no effect. `cardCs` is one-hot for the held select (bit 0 for select 0, bit 1 for select 1), and `busAddr` keeps the held address, including across a resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access request, held until `cpuDone` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuWord | input | 1 | 1 = two-beat word, 0 = one-beat byte |
| cpuSel | input | 1 | Companion device index |
| cpuAddr | input | 12 | Access address |
| cpuWdata | input | 16 | Write data |
| cpuRdata | output | 16 | Assembled read data, valid with `cpuDone` |
| cpuDone | output | 1 | One-clock completion pulse |
| busReq | output | 1 | Shared bus request |
| busGnt | input | 1 | Shared bus grant |
| cardReady | input | 1 | Companion ready |
| cardCs | output | 2 | One-hot chip selects |
| busAddr | output | 12 | Bus address |
| busWe | output | 1 | Bus write strobe |
| busWdata | output | 8 | Bus write data beat |
| busRdata | input | 8 | Bus read data beat |

## Verification
The sample of ready at the end of the request phase and the bus arbitration can act in the same clock. A grant that is withheld for one or more clocks, both before the first request phase and before a resume, lands in the clocks where the block also watches ready. That case is provoked with table entries that combine a grant delay with a split access. It is judged by the exact completion latency, by the count of chip-select clocks (which must include exactly one resume clock), and by the read beats that the bench's card model numbers by chip-select clock. Throughout, the bench also changes the select and address inputs after acceptance, and checks on every clock that the chip select never appears without a grant.

// File: rtl/cbmPkg.sv
package cbmPkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ARB, S_REQ1, S_REQ2, S_PARK, S_RARB, S_RESUME, S_DATA, S_DONE
  } cbmState_t;

  typedef struct packed {
    logic load;      // capture CPU request fields
    logic drive;     // block owns the bus phase (chip select allowed)
    logic dataBeat;  // current clock is a data beat
    logic beatHi;    // data beat is the upper half
  } cbmStrobe_t;
endpackage

// File: rtl/cbmCtrl.sv
module cbmCtrl
  import cbmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       busGnt,
  input  logic       cardReady,
  input  logic       isWord,
  output cbmStrobe_t strobe,
  output logic       busReq,
  output logic       cpuDone,
  output cbmState_t  state
);
  cbmState_t nextState;
  logic      beatQ;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:   if (cpuReq) nextState = S_ARB;
      S_ARB:    if (busGnt) nextState = S_REQ1;
      S_REQ1:   nextState = S_REQ2;
      S_REQ2:   nextState = cardReady ? S_DATA : S_PARK;
      S_PARK:   if (cardReady) nextState = S_RARB;
      S_RARB:   if (busGnt) nextState = S_RESUME;
      S_RESUME: nextState = S_DATA;
      S_DATA:   nextState = (isWord && !beatQ) ? S_DATA : S_DONE;
      S_DONE:   nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      beatQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state != S_DATA) beatQ <= 1'b0;
      else if (isWord && !beatQ) beatQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.load     = (state == S_IDLE) && cpuReq;
    strobe.drive    = state inside {S_REQ1, S_REQ2, S_RESUME, S_DATA};
    strobe.dataBeat = (state == S_DATA);
    strobe.beatHi   = beatQ;
    busReq  = state inside {S_ARB, S_REQ1, S_REQ2, S_RARB, S_RESUME, S_DATA};
    cpuDone = (state == S_DONE);
  end
endmodule

// File: rtl/cbmData.sv
module cbmData
  import cbmPkg::*;
#(
  parameter int AW     = 12,
  parameter int BW     = 8,
  parameter int NUM_CS = 2,
  localparam int DW    = 2 * BW,
  localparam int SELW  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbmStrobe_t        strobe,
  input  logic              busGnt,
  input  logic              cpuWrite,
  input  logic              cpuWord,
  input  logic [SELW-1:0]   cpuSel,
  input  logic [AW-1:0]     cpuAddr,
  input  logic [DW-1:0]     cpuWdata,
  input  logic [BW-1:0]     busRdata,
  output logic              isWord,
  output logic [NUM_CS-1:0] cardCs,
  output logic [AW-1:0]     busAddr,
  output logic              busWe,
  output logic [BW-1:0]     busWdata,
  output logic [DW-1:0]     cpuRdata
);
  logic [AW-1:0]   addrQ;
  logic [SELW-1:0] selQ;
  logic            writeQ, wordQ;
  logic [DW-1:0]   wdataQ, rdataQ;
  logic            owned;

  assign owned = strobe.drive && busGnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      selQ   <= '0;
      writeQ <= 1'b0;
      wordQ  <= 1'b0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else if (strobe.load) begin
      addrQ  <= cpuAddr;
      selQ   <= cpuSel;
      writeQ <= cpuWrite;
      wordQ  <= cpuWord;
      wdataQ <= cpuWdata;
      rdataQ <= '0;
    end else if (strobe.dataBeat && owned && !writeQ) begin
      if (strobe.beatHi) rdataQ[DW-1:BW] <= busRdata;
      else               rdataQ[BW-1:0]  <= busRdata;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cardCs[i] = owned && (selQ == SELW'(i));
  end

  assign isWord   = wordQ;
  assign busAddr  = addrQ;
  assign busWe    = owned && writeQ;
  assign busWdata = (strobe.dataBeat && owned && writeQ)
                  ? (strobe.beatHi ? wdataQ[DW-1:BW] : wdataQ[BW-1:0]) : '0;
  assign cpuRdata = rdataQ;
endmodule

// File: rtl/cardBusMaster.sv
module cardBusMaster
  import cbmPkg::*;
#(
  parameter int AW     = 12,
  parameter int BW     = 8,
  parameter int NUM_CS = 2,
  localparam int DW    = 2 * BW,
  localparam int SELW  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic              cpuWord,
  input  logic [SELW-1:0]   cpuSel,
  input  logic [AW-1:0]     cpuAddr,
  input  logic [DW-1:0]     cpuWdata,
  output logic [DW-1:0]     cpuRdata,
  output logic              cpuDone,
  output logic              busReq,
  input  logic              busGnt,
  input  logic              cardReady,
  output logic [NUM_CS-1:0] cardCs,
  output logic [AW-1:0]     busAddr,
  output logic              busWe,
  output logic [BW-1:0]     busWdata,
  input  logic [BW-1:0]     busRdata
);
  cbmStrobe_t strobe;
  cbmState_t  curState;
  logic       isWord;

  cbmCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .busGnt(busGnt),
    .cardReady(cardReady), .isWord(isWord), .strobe(strobe),
    .busReq(busReq), .cpuDone(cpuDone), .state(curState)
  );

  cbmData #(.AW(AW), .BW(BW), .NUM_CS(NUM_CS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busGnt(busGnt),
    .cpuWrite(cpuWrite), .cpuWord(cpuWord), .cpuSel(cpuSel),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .busRdata(busRdata),
    .isWord(isWord), .cardCs(cardCs), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .cpuRdata(cpuRdata)
  );
endmodule

// File: rtl/cbmChecker.sv
module cbmChecker
  import cbmPkg::*;
#(
  parameter int AW     = 12,
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGnt,
  input logic              cardReady,
  input logic              cpuDone,
  input logic [NUM_CS-1:0] cardCs,
  input logic [AW-1:0]     busAddr,
  input cbmState_t         curState
);
  a_r2_cs_needs_gnt: assert property (@(posedge clk) disable iff (!rstN)
    (|cardCs) |-> busGnt);

  a_r10_cs_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cardCs));

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (curState != S_IDLE && $past(curState) != S_IDLE) |-> $stable(busAddr));

  a_r3_ready_continues: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curState) == S_REQ2 && $past(cardReady)) |-> curState == S_DATA);

  a_r4_ready_low_parks: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curState) == S_REQ2 && !$past(cardReady)) |-> curState == S_PARK);

  a_r4_park_releases: assert property (@(posedge clk) disable iff (!rstN)
    (curState == S_PARK) |-> (!busReq && cardCs == '0));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> (!busReq && cardCs == '0));
endmodule

bind cardBusMaster cbmChecker #(.AW(AW), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busGnt(busGnt),
  .cardReady(cardReady), .cpuDone(cpuDone), .cardCs(cardCs),
  .busAddr(busAddr), .curState(curState)
);

// File: tb/cardBusMaster_tb.sv
module cardBusMaster_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWrite = 1'b0, cpuWord = 1'b0;
  logic [0:0]  cpuSel = '0;
  logic [11:0] cpuAddr = '0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic        cpuDone, busReq, busWe;
  logic        busGnt = 1'b0, cardReady = 1'b0;
  logic [1:0]  cardCs;
  logic [11:0] busAddr;
  logic [7:0]  busWdata;
  logic [7:0]  busRdata = '0;

  int cmpCnt = 0, errCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cardBusMaster u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuWord(cpuWord), .cpuSel(cpuSel), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuDone(cpuDone),
    .busReq(busReq), .busGnt(busGnt), .cardReady(cardReady),
    .cardCs(cardCs), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  typedef struct packed {
    bit        wr;
    bit        word;
    bit        sel;
    bit [11:0] addr;
    bit [15:0] wdata;
    bit        split;
    bit [3:0]  gntDly;
    bit [9:0]  parkLen;
    bit [9:0]  expLat;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 12'h123, 16'h0000, 1'b0, 4'd0, 10'd0,   10'd6},
    '{1'b0, 1'b0, 1'b1, 12'h0F0, 16'h0000, 1'b0, 4'd0, 10'd0,   10'd5},
    '{1'b1, 1'b1, 1'b0, 12'h200, 16'hBEEF, 1'b0, 4'd2, 10'd0,   10'd8},
    '{1'b1, 1'b0, 1'b1, 12'h3FF, 16'h1234, 1'b0, 4'd0, 10'd0,   10'd5},
    '{1'b0, 1'b1, 1'b1, 12'h456, 16'h0000, 1'b1, 4'd0, 10'd4,   10'd12},
    '{1'b0, 1'b0, 1'b0, 12'h789, 16'h0000, 1'b1, 4'd1, 10'd2,   10'd11},
    '{1'b1, 1'b1, 1'b1, 12'hABC, 16'hCAFE, 1'b1, 4'd0, 10'd3,   10'd11},
    '{1'b0, 1'b1, 1'b0, 12'h001, 16'h0000, 1'b1, 4'd0, 10'd300, 10'd308}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    cmpCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runAccess(input vec_t v);
    int cyc = 0, csCnt = 0, parkCnt = 0, rc = 0, tail = -1;
    int doneCnt = 0, lat = 0, nb = 0;
    int csBad = 0, gntBad = 0, parkBad = 0, relBad = 0;
    int dStart;
    logic [7:0]  wb [2];
    logic [15:0] rd = '0, expRd;
    logic [7:0]  b0;
    bit inPark;
    dStart = v.split ? 3 : 2;
    wb[0] = '0; wb[1] = '0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = v.wr; cpuWord = v.word; cpuSel = v.sel;
    cpuAddr = v.addr; cpuWdata = v.wdata; cardReady = !v.split;
    while (tail != 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      cpuAddr = ~v.addr;   // R10: later changes must be ignored
      cpuSel  = ~v.sel;
      inPark = v.split && !cardReady && csCnt == 2;
      if (inPark) begin
        if (busReq || cardCs != 2'b00) parkBad++;
        parkCnt++;
        if (parkCnt >= int'(v.parkLen)) cardReady = 1'b1;
      end
      if (busReq) rc++; else rc = 0;
      busGnt = busReq && (rc > int'(v.gntDly));
      #1;
      if (cardCs != 2'b00) begin
        if (cardCs != (2'b01 << v.sel) || busAddr != v.addr) csBad++;
        if (!busGnt) gntBad++;
        busRdata = v.addr[7:0] + 8'(csCnt);
        if (busWe && csCnt >= dStart && nb < 2) begin
          wb[nb] = busWdata;
          nb++;
        end
        csCnt++;
      end
      if (cpuDone) begin
        doneCnt++;
        lat = cyc;
        rd = cpuRdata;
        if (busReq || cardCs != 2'b00) relBad++;
        cpuReq = 1'b0;
        tail = 3;
      end else if (tail > 0) tail--;
    end
    busGnt = 1'b0; cardReady = 1'b0;

    check(doneCnt == 1, "R8", "done pulses", doneCnt, 1);
    check(relBad == 0, "R8", "bus held in done cycle", relBad, 0);
    check(csBad == 0, "R10", "select/address drift", csBad, 0);
    check(gntBad == 0, "R2", "chip select without grant", gntBad, 0);
    check(lat == int'(v.expLat), v.split ? "R5" : "R3", "latency", lat, int'(v.expLat));
    if (v.split) begin
      check(parkBad == 0 && parkCnt >= int'(v.parkLen), "R4", "park release",
            parkBad, 0);
      check(csCnt == (v.word ? 5 : 4), "R5", "cs clocks split", csCnt,
            v.word ? 5 : 4);
      if (v.parkLen >= 10'd300)
        check(doneCnt == 1 && lat == int'(v.expLat), "R9", "long park completes",
              lat, int'(v.expLat));
    end else begin
      check(csCnt == (v.word ? 4 : 3), "R3", "cs clocks combined", csCnt,
            v.word ? 4 : 3);
    end
    if (v.wr) begin
      check(nb == (v.word ? 2 : 1), "R7", "write beats", nb, v.word ? 2 : 1);
      check(wb[0] == v.wdata[7:0], "R7", "write beat 0", wb[0], v.wdata[7:0]);
      if (v.word)
        check(wb[1] == v.wdata[15:8], "R7", "write beat 1", wb[1], v.wdata[15:8]);
    end else begin
      b0 = v.addr[7:0] + (v.split ? 8'd3 : 8'd2);
      expRd = v.word ? {b0 + 8'd1, b0} : {8'h00, b0};
      check(rd == expRd, "R6", "read data", rd, expRd);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      cmpCnt++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busReq && cardCs == 2'b00 && !cpuDone, "R1", "reset outputs",
          {busReq, cardCs, cpuDone}, 0);
    check(cpuRdata == 16'h0, "R1", "reset read data", cpuRdata, 0);

    for (int i = 0; i < NVEC; i++) runAccess(VEC[i]);

    // R1: reset in the middle of a parked access
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuWord = 1'b1; cpuSel = 1'b1;
    cpuAddr = 12'h555; cardReady = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      busGnt = busReq;
    end
    check(!busReq && cardCs == 2'b00, "R4", "parked before reset",
          {busReq, cardCs}, 0);
    rstN = 1'b0; cpuReq = 1'b0; busGnt = 1'b0;
    @(negedge clk);
    cardReady = 1'b1;
    check(!busReq && cardCs == 2'b00 && !cpuDone, "R1", "mid-access reset",
          {busReq, cardCs, cpuDone}, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busReq && cardCs == 2'b00 && !cpuDone, "R1", "no resume after reset",
          {busReq, cardCs, cpuDone}, 0);
    cardReady = 1'b0;

    // access after the reset still works
    runAccess(VEC[0]);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end
endmodule